// File: doc/BRIEF.md
# Tagged Pointer Dereference Unit

This block executes one step of a dereference instruction on 32-bit tagged words. The operand word arrives with its instruction. When it is a reference to a variable cell, the unit reads that cell through a synchronous memory port. It then either writes the loaded word back to the operand register and points the program counter at the same instruction again, or it reports that the variable is unbound. Each execution follows exactly one link. A chain of any length is therefore walked by re-issuing the same single-cycle instruction through the normal context scheduler, so other contexts can issue between links.

When the operand is no longer a reference, the unit ends the walk. Checking variants then test the primary tag for a list, a vector or a constant, and jump to a failure target on a mismatch. The list variant with car load also reads the first element of the list. An unbound variable found by a checking variant is copied to the suspension register, and control moves to a suspend target. The instruction therefore has three outcomes: fall through, suspend, or fail. The suspend target is the instruction address plus a signed offset. The failure target comes from the alternative-pointer register. The register file, the scheduler and the memory sit outside the block.

Top module: `deref_unit`

## Requirements
- R1: Word layout: bits 31:30 hold mark bits, bits 29:28 hold the primary tag (00 variable reference, 01 list, 10 vector, 11 constant), and bits 27:0 hold an address or a value. For constants, bits 27:24 hold the cell type (0000 integer, 0001 symbol, 0010 to 1111 undefined). The undefined code is a constant with cell type 1111.
- R2: An issued operand whose tag is a variable reference raises `mem_rd_en_o` in the same cycle, with `mem_addr_o` equal to bits 27:0 of the operand. An operand with any other tag issues no read, except for the case in R10.
- R3: A result appears on `done_o` exactly one cycle after `valid_i`, carrying that issue's `ctx_i`. Without an issue, `done_o` is low and every write enable is low. After reset, `done_o` is low.
- R4: A loaded cell that is bound gives outcome REEXEC (code 1), `npc_o` equal to the issuing pc, and `wb_en_o` high with `wb_data_o` equal to the loaded word. Bound means neither self-pointing nor the undefined code.
- R5: A loaded cell is unbound when its tag is a variable reference whose bits 27:0 equal the operand's bits 27:0. Mark bits are ignored in this comparison.
- R6: A loaded cell that holds the undefined code is also unbound.
- R7: Checking variants are 1 list, 2 vector, 3 constant, and 4 list with car load. On an unbound variable they give outcome SUSPEND (code 2), `susp_we_o` high with `susp_data_o` equal to the operand word, and `npc_o` equal to pc plus the sign-extended offset.
- R8: The plain variant 0, and the unused codes 5 to 7, give outcome NEXT (code 0) with `npc_o` equal to pc+1 and no write, both on an unbound variable and on any non-reference operand.
- R9: A checking variant whose non-reference operand fails its tag test gives outcome FAIL (code 3), `npc_o` equal to `alt_i` as it was at issue, and no write. A passing test gives NEXT with `npc_o` equal to pc+1.
- R10: Variant 4 with a list operand reads the cell at the operand's bits 27:0. The next cycle it gives NEXT with `car_we_o` high and `car_data_o` equal to the loaded word.
- R11: The constant check passes only for cell types 0000 and 0001.
- R12: At most one of `wb_en_o`, `susp_we_o` and `car_we_o` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Instruction issued this cycle |
| ctx_i | input | CTX_W | Issuing context |
| variant_i | input | 3 | Instruction variant code |
| word_i | input | 32 | Operand register value |
| pc_i | input | PC_W | Address of the instruction |
| offset_i | input | OFF_W | Signed suspend offset |
| alt_i | input | PC_W | Alternative-pointer register value |
| mem_rd_en_o | output | 1 | Memory read strobe |
| mem_addr_o | output | 28 | Memory read address |
| mem_rdata_i | input | 32 | Read data, one cycle after the strobe |
| done_o | output | 1 | Result valid |
| ctx_o | output | CTX_W | Context of the result |
| outcome_o | output | 2 | 0 NEXT, 1 REEXEC, 2 SUSPEND, 3 FAIL |
| npc_o | output | PC_W | Next pc for the context |
| wb_en_o | output | 1 | Write the operand register |
| wb_data_o | output | 32 | Operand register write value |
| susp_we_o | output | 1 | Write the suspension register |
| susp_data_o | output | 32 | Suspension register write value |
| car_we_o | output | 1 | Write the loaded car |
| car_data_o | output | 32 | Car value |

## Verification
The assertions assume that the memory returns read data exactly one cycle after each strobe. They also assume that `pc_i`, `offset_i` and `alt_i` are meaningful whenever `valid_i` is high. The stimulus keeps within these assumptions by serving reads from a one-cycle memory model in the bench, and by driving every field on each issue. The stimulus walks multi-link chains by feeding each written-back word into the next issue. It ends those chains on self-pointing cells, on undefined-code cells, and on every tag class, and it varies the mark bits so that they cannot affect a decision.

// File: rtl/deref_pkg.sv
package deref_pkg;
  localparam int WORD_W = 32;
  localparam int ADDR_W = 28;

  localparam logic [1:0] TAG_VAR   = 2'b00;
  localparam logic [1:0] TAG_LIST  = 2'b01;
  localparam logic [1:0] TAG_VEC   = 2'b10;
  localparam logic [1:0] TAG_CONST = 2'b11;
  localparam logic [3:0] CT_UNDEF  = 4'b1111;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [2:0] {
    V_PLAIN   = 3'd0,
    V_LIST    = 3'd1,
    V_VEC     = 3'd2,
    V_CONST   = 3'd3,
    V_LISTCAR = 3'd4
  } variant_e;

  typedef enum logic [1:0] {
    OC_NEXT    = 2'd0,
    OC_REEXEC  = 2'd1,
    OC_SUSPEND = 2'd2,
    OC_FAIL    = 2'd3
  } outcome_e;

  function automatic logic [1:0] tag_of(word_t w);
    return w[29:28];
  endfunction

  function automatic logic [3:0] ctype_of(word_t w);
    return w[27:24];
  endfunction
endpackage

// File: rtl/deref_issue.sv
module deref_issue
  import deref_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int OFF_W = 12,
  parameter int CTX_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [CTX_W-1:0]  ctx_i,
  input  logic [2:0]        variant_i,
  input  word_t             word_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [OFF_W-1:0]  offset_i,
  input  logic [PC_W-1:0]   alt_i,
  output logic              mem_rd_en_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              b_valid_o,
  output logic [CTX_W-1:0]  b_ctx_o,
  output logic [2:0]        b_variant_o,
  output word_t             b_word_o,
  output logic [PC_W-1:0]   b_pc_o,
  output logic [PC_W-1:0]   b_susp_pc_o,
  output logic [PC_W-1:0]   b_alt_o
);
  localparam int EXT_W = PC_W - OFF_W;

  logic [PC_W-1:0] susp_pc;
  logic            car_rd;

  assign car_rd      = (variant_i == V_LISTCAR) && (tag_of(word_i) == TAG_LIST);
  assign mem_rd_en_o = valid_i && ((tag_of(word_i) == TAG_VAR) || car_rd);
  assign mem_addr_o  = word_i[ADDR_W-1:0];
  assign susp_pc     = pc_i + {{EXT_W{offset_i[OFF_W-1]}}, offset_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      b_valid_o   <= 1'b0;
      b_ctx_o     <= '0;
      b_variant_o <= '0;
      b_word_o    <= '0;
      b_pc_o      <= '0;
      b_susp_pc_o <= '0;
      b_alt_o     <= '0;
    end else begin
      b_valid_o <= valid_i;
      if (valid_i) begin
        b_ctx_o     <= ctx_i;
        b_variant_o <= variant_i;
        b_word_o    <= word_i;
        b_pc_o      <= pc_i;
        b_susp_pc_o <= susp_pc;
        b_alt_o     <= alt_i;
      end
    end
  end
endmodule

// File: rtl/deref_resolve.sv
module deref_resolve
  import deref_pkg::*;
#(
  parameter int PC_W = 16
) (
  input  logic            b_valid_i,
  input  logic [2:0]      b_variant_i,
  input  word_t           b_word_i,
  input  logic [PC_W-1:0] b_pc_i,
  input  logic [PC_W-1:0] b_susp_pc_i,
  input  logic [PC_W-1:0] b_alt_i,
  input  word_t           rdata_i,
  output logic [1:0]      outcome_o,
  output logic [PC_W-1:0] npc_o,
  output logic            wb_en_o,
  output logic            susp_we_o,
  output logic            car_we_o
);
  logic checking, unbound, type_ok;
  outcome_e oc;

  assign checking = (b_variant_i >= 3'd1) && (b_variant_i <= 3'd4);

  // self-reference compares address bits only, marks are ignored
  assign unbound = ((tag_of(rdata_i) == TAG_VAR) &&
                    (rdata_i[ADDR_W-1:0] == b_word_i[ADDR_W-1:0])) ||
                   ((tag_of(rdata_i) == TAG_CONST) && (ctype_of(rdata_i) == CT_UNDEF));

  always_comb begin
    unique case (b_variant_i)
      V_LIST, V_LISTCAR: type_ok = tag_of(b_word_i) == TAG_LIST;
      V_VEC:             type_ok = tag_of(b_word_i) == TAG_VEC;
      V_CONST:           type_ok = (tag_of(b_word_i) == TAG_CONST) &&
                                   (ctype_of(b_word_i) <= 4'd1);
      default:           type_ok = 1'b1;
    endcase
  end

  always_comb begin
    oc        = OC_NEXT;
    npc_o     = b_pc_i + PC_W'(1);
    wb_en_o   = 1'b0;
    susp_we_o = 1'b0;
    car_we_o  = 1'b0;
    if (tag_of(b_word_i) == TAG_VAR) begin
      if (!unbound) begin
        oc      = OC_REEXEC;
        npc_o   = b_pc_i;
        wb_en_o = b_valid_i;
      end else if (checking) begin
        oc        = OC_SUSPEND;
        npc_o     = b_susp_pc_i;
        susp_we_o = b_valid_i;
      end
    end else if (!type_ok) begin
      oc    = OC_FAIL;
      npc_o = b_alt_i;
    end else if (b_variant_i == V_LISTCAR) begin
      car_we_o = b_valid_i;
    end
  end

  assign outcome_o = oc;
endmodule

// File: rtl/deref_unit.sv
module deref_unit
  import deref_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int OFF_W = 12,
  parameter int CTX_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [CTX_W-1:0]  ctx_i,
  input  logic [2:0]        variant_i,
  input  logic [31:0]       word_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [OFF_W-1:0]  offset_i,
  input  logic [PC_W-1:0]   alt_i,
  output logic              mem_rd_en_o,
  output logic [27:0]       mem_addr_o,
  input  logic [31:0]       mem_rdata_i,
  output logic              done_o,
  output logic [CTX_W-1:0]  ctx_o,
  output logic [1:0]        outcome_o,
  output logic [PC_W-1:0]   npc_o,
  output logic              wb_en_o,
  output logic [31:0]       wb_data_o,
  output logic              susp_we_o,
  output logic [31:0]       susp_data_o,
  output logic              car_we_o,
  output logic [31:0]       car_data_o
);
  logic            b_valid;
  logic [2:0]      b_variant;
  word_t           b_word;
  logic [PC_W-1:0] b_pc, b_susp_pc, b_alt;

  deref_issue #(.PC_W(PC_W), .OFF_W(OFF_W), .CTX_W(CTX_W)) i_issue (
    .clk_i, .rst_ni, .valid_i, .ctx_i, .variant_i, .word_i, .pc_i, .offset_i, .alt_i,
    .mem_rd_en_o, .mem_addr_o,
    .b_valid_o(b_valid), .b_ctx_o(ctx_o), .b_variant_o(b_variant), .b_word_o(b_word),
    .b_pc_o(b_pc), .b_susp_pc_o(b_susp_pc), .b_alt_o(b_alt)
  );

  deref_resolve #(.PC_W(PC_W)) i_resolve (
    .b_valid_i(b_valid), .b_variant_i(b_variant), .b_word_i(b_word), .b_pc_i(b_pc),
    .b_susp_pc_i(b_susp_pc), .b_alt_i(b_alt), .rdata_i(mem_rdata_i),
    .outcome_o, .npc_o, .wb_en_o, .susp_we_o, .car_we_o
  );

  assign done_o      = b_valid;
  assign wb_data_o   = mem_rdata_i;
  assign car_data_o  = mem_rdata_i;
  assign susp_data_o = b_word;
endmodule

// File: rtl/deref_unit_chk.sv
module deref_unit_chk #(
  parameter int PC_W  = 16,
  parameter int OFF_W = 12,
  parameter int CTX_W = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [2:0]       variant_i,
  input logic [31:0]      word_i,
  input logic [PC_W-1:0]  pc_i,
  input logic [PC_W-1:0]  alt_i,
  input logic             mem_rd_en_o,
  input logic [27:0]      mem_addr_o,
  input logic             done_o,
  input logic [1:0]       outcome_o,
  input logic [PC_W-1:0]  npc_o,
  input logic             wb_en_o,
  input logic             susp_we_o,
  input logic             car_we_o
);
  a_r2_var_reads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && word_i[29:28] == 2'b00) |-> (mem_rd_en_o && mem_addr_o == word_i[27:0]));

  a_r2_no_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && word_i[29:28] != 2'b00 && !(variant_i == 3'd4 && word_i[29:28] == 2'b01))
      |-> !mem_rd_en_o);

  a_r3_done_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> done_o);

  a_r3_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!done_o && !wb_en_o && !susp_we_o && !car_we_o));

  a_r4_reexec_pc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i ##1 (done_o && outcome_o == 2'd1) |-> (npc_o == $past(pc_i) && wb_en_o));

  a_r9_fail_alt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i ##1 (done_o && outcome_o == 2'd3) |-> (npc_o == $past(alt_i)));

  a_r7_susp_outcome: assert property (@(posedge clk_i) disable iff (!rst_ni)
    susp_we_o |-> (outcome_o == 2'd2));

  a_r12_one_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wb_en_o, susp_we_o, car_we_o}));
endmodule

bind deref_unit deref_unit_chk #(.PC_W(PC_W), .OFF_W(OFF_W), .CTX_W(CTX_W)) i_chk (.*);

// File: tb/test_deref_unit.sv
module test_deref_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  ctx_i = '0;
  logic [2:0]  variant_i = '0;
  logic [31:0] word_i = '0;
  logic [15:0] pc_i = '0;
  logic [11:0] offset_i = '0;
  logic [15:0] alt_i = '0;
  logic        mem_rd_en_o;
  logic [27:0] mem_addr_o;
  logic [31:0] mem_rdata_i = '0;
  logic        done_o;
  logic [1:0]  ctx_o, outcome_o;
  logic [15:0] npc_o;
  logic        wb_en_o, susp_we_o, car_we_o;
  logic [31:0] wb_data_o, susp_data_o, car_data_o;

  int errors = 0, checks = 0;
  bit ended = 0;
  logic [31:0] mem [256];

  typedef logic [1+2+2+16+3*33-1:0] res_t;
  res_t exp_res;
  logic [31:0] exp_wb;
  logic [1:0]  exp_oc;

  always #10 clk_i = ~clk_i;

  always_ff @(posedge clk_i) if (mem_rd_en_o) mem_rdata_i <= mem[mem_addr_o[7:0]];

  deref_unit i_deref_unit (.*);

  function automatic res_t canon(logic d, logic [1:0] c, logic [1:0] o, logic [15:0] n,
                                 logic we, logic [31:0] wd, logic se, logic [31:0] sd,
                                 logic ce, logic [31:0] cd);
    if (!d) return {1'b0, 2'b0, 2'b0, 16'h0, we, 32'h0, se, 32'h0, ce, 32'h0};
    return {d, c, o, n, we, we ? wd : 32'h0, se, se ? sd : 32'h0, ce, ce ? cd : 32'h0};
  endfunction

  task automatic fail_line(string r, string what, logic [255:0] act, logic [255:0] exp);
    errors++;
    $display("FAIL %s %s actual=%h expected=%h", r, what, act, exp);
  endtask

  task automatic step(bit v, logic [2:0] vr, logic [31:0] w, logic [15:0] pc,
                      logic [11:0] off, logic [15:0] alt, logic [1:0] ctx, string r);
    bit er;
    bit chk_v;
    bit ok;
    logic [31:0] c;
    logic [1:0] oc;
    logic [15:0] n;
    bit we, se, ce;
    valid_i = v; variant_i = vr; word_i = w; pc_i = pc; offset_i = off; alt_i = alt; ctx_i = ctx;
    er = v && (w[29:28] == 2'b00 || (vr == 3'd4 && w[29:28] == 2'b01));
    #1;
    checks++;
    if (mem_rd_en_o !== er || (er && mem_addr_o !== w[27:0]))
      fail_line(r, "read", {mem_rd_en_o, mem_addr_o}, {er, w[27:0]});
    chk_v = (vr >= 1 && vr <= 4);
    oc = 2'd0; n = pc + 16'd1; we = 0; se = 0; ce = 0; c = mem[w[7:0]];
    if (w[29:28] == 2'b00) begin
      if ((c[29:28] == 2'b00 && c[27:0] == w[27:0]) || (c[29:28] == 2'b11 && c[27:24] == 4'hF)) begin
        if (chk_v) begin oc = 2'd2; n = pc + {{4{off[11]}}, off}; se = 1; end
      end else begin oc = 2'd1; n = pc; we = 1; end
    end else begin
      case (vr)
        3'd1, 3'd4: ok = w[29:28] == 2'b01;
        3'd2:       ok = w[29:28] == 2'b10;
        3'd3:       ok = w[29:28] == 2'b11 && w[27:24] <= 4'd1;
        default:    ok = 1;
      endcase
      if (!ok) begin oc = 2'd3; n = alt; end
      else if (vr == 3'd4) ce = 1;
    end
    exp_res = canon(v, ctx, oc, n, v && we, c, v && se, w, v && ce, c);
    exp_wb = c; exp_oc = v ? oc : 2'd0;
    @(posedge clk_i); #1;
    valid_i = 0;
    @(negedge clk_i);
    checks++;
    if (canon(done_o, ctx_o, outcome_o, npc_o, wb_en_o, wb_data_o, susp_we_o, susp_data_o,
              car_we_o, car_data_o) !== exp_res)
      fail_line(r, "result", canon(done_o, ctx_o, outcome_o, npc_o, wb_en_o, wb_data_o,
                susp_we_o, susp_data_o, car_we_o, car_data_o), exp_res);
  endtask

  function automatic logic [31:0] mk(logic [1:0] m, logic [1:0] t, logic [27:0] a);
    return {m, t, a};
  endfunction

  task automatic walk(logic [2:0] vr, logic [31:0] start, string r);
    logic [31:0] cur = start;
    for (int i = 0; i < 8; i++) begin
      step(1, vr, cur, 16'h0100, 12'hFF0, 16'h0777, 2'(i), r);
      if (exp_oc != 2'd1) break;
      cur = exp_wb;
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = mk(2'b00, 2'b11, 28'h0000005);
    mem[10] = mk(2'b01, 2'b00, 28'd20);
    mem[20] = mk(2'b00, 2'b00, 28'd30);
    mem[30] = mk(2'b10, 2'b00, 28'd30);          // self, different marks
    mem[40] = mk(2'b00, 2'b00, 28'd41);
    mem[41] = mk(2'b00, 2'b01, 28'd50);
    mem[50] = mk(2'b00, 2'b11, 28'h0000007);
    mem[60] = mk(2'b00, 2'b11, 28'hF000000);     // undefined code
    mem[70] = mk(2'b00, 2'b10, 28'd80);

    repeat (2) @(negedge clk_i);
    checks++;
    if (done_o !== 1'b0 || wb_en_o || susp_we_o || car_we_o)
      fail_line("R3", "reset", {done_o, wb_en_o, susp_we_o, car_we_o}, 0);
    rst_ni = 1;
    @(negedge clk_i);

    step(0, 3'd1, mk(0, 0, 28'd10), 16'h10, 0, 0, 0, "R3_idle");
    walk(3'd1, mk(2'b11, 2'b00, 28'd10), "R4_R5_R7_R11_chain_suspend");
    walk(3'd0, mk(0, 0, 28'd10), "R8_plain_unbound");
    walk(3'd4, mk(0, 0, 28'd40), "R10_listcar_chain");
    walk(3'd3, mk(0, 0, 28'd40), "R11_const_fail_on_list");
    step(1, 3'd2, mk(0, 0, 28'd60), 16'h0200, 12'h010, 16'h0ABC, 2'd1, "R6_undef_suspend");
    step(1, 3'd0, mk(0, 0, 28'd60), 16'h0200, 12'h010, 16'h0ABC, 2'd1, "R6_R8_undef_plain");
    walk(3'd2, mk(0, 0, 28'd70), "R9_vec_pass");
    step(1, 3'd1, mk(0, 2'b10, 28'd80), 16'h0300, 0, 16'h0444, 2'd2, "R9_list_on_vec");
    step(1, 3'd3, mk(0, 2'b11, 28'h0000009), 16'h0300, 0, 16'h0444, 2'd2, "R11_int");
    step(1, 3'd3, mk(0, 2'b11, 28'h1000009), 16'h0300, 0, 16'h0444, 2'd2, "R11_symbol");
    step(1, 3'd3, mk(0, 2'b11, 28'h2000009), 16'h0300, 0, 16'h0444, 2'd2, "R11_type2_fail");
    step(1, 3'd3, mk(0, 2'b11, 28'hE000009), 16'h0300, 0, 16'h0444, 2'd2, "R11_typeE_fail");
    step(1, 3'd6, mk(0, 2'b10, 28'd1), 16'h0300, 0, 16'h0444, 2'd3, "R8_unused_code");
    step(1, 3'd4, mk(0, 2'b10, 28'd1), 16'h0300, 0, 16'h0444, 2'd3, "R2_R10_no_car_on_vec");
    step(1, 3'd4, mk(2'b11, 2'b01, 28'd50), 16'h0300, 0, 16'h0444, 2'd0, "R1_R10_car_marks");
    step(1, 3'd1, mk(2'b01, 2'b00, 28'd41), 16'hFFFF, 12'h001, 16'h0, 2'd0, "R4_pc_top");
    step(1, 3'd1, mk(0, 0, 28'd30), 16'h0005, 12'h800, 16'h0, 2'd1, "R7_neg_offset");
    step(0, 3'd0, 0, 0, 0, 0, 0, "R12_idle_end");
    finish_run();
  end
endmodule